// File: doc/BRIEF.md
# Register-to-Register ALU with Flag Output

This block is the 8-bit arithmetic and logic stage that serves the register-to-register instruction group of a small interpreted-language processor. Each issued operation carries a 4-bit function code and two 8-bit operands: the destination register's value (X) and the source register's value (Y). One clock later the block presents the 8-bit result with a write-enable for the destination register. It also presents a flag byte and a flag write-enable aimed at the dedicated flag register, which is the last entry of the general register file.

Each arithmetic and shift function produces its own flag. A carry comes from addition. A not-borrow with a strict comparison comes from both subtraction directions. The bit shifted out comes from the shifts. Moves and bitwise operations leave the flag register alone. The issuing logic indicates when the destination register is the flag register itself. In that case a flag write suppresses the result write, so the flag value is what the register ends up holding.

Top module: `vreg_alu`

## Requirements
- R1: Function codes 0, 1, 2 and 3 give Y, X|Y, X&Y and X^Y respectively, with res_we=1 and flag_we=0.
- R2: Function code 4 gives (X+Y) mod 256. The flag is 8'h01 when X+Y>255, else 8'h00, with flag_we=1.
- R3: Function code 5 gives (X-Y) mod 256. The flag is 8'h01 only when X>Y strictly, else 8'h00, with flag_we=1.
- R4: Function code 7 gives (Y-X) mod 256. The flag is 8'h01 only when Y>X strictly, else 8'h00, with flag_we=1.
- R5: Function code 6 gives X>>1. The flag is {7'b0, X[0]}, with flag_we=1.
- R6: Function code 14 (hex E) gives X<<1 mod 256. The flag is {7'b0, X[7]}, with flag_we=1.
- R7: Function codes 8 to 13 and 15 assert neither res_we nor flag_we, and res_data and flag_data read 0.
- R8: When dst_is_flag=1 and the function writes the flag (codes 4, 5, 6, 7, 14), res_we=0 and flag_we=1. For codes 0 to 3 with dst_is_flag=1, res_we=1.
- R9: Outputs reflect the operation issued on the previous rising clock edge. A cycle with issue=0 produces res_we=0 and flag_we=0 on the next cycle.
- R10: While rst_n=0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation valid this cycle |
| func | input | 4 | Function code |
| x_val | input | 8 | Destination register value (X) |
| y_val | input | 8 | Source register value (Y) |
| dst_is_flag | input | 1 | Destination register is the flag register |
| res_data | output | 8 | Result for the destination register |
| res_we | output | 1 | Destination register write-enable |
| flag_data | output | 8 | Value for the flag register (0 or 1) |
| flag_we | output | 1 | Flag register write-enable |

## Verification
A result write and a flag write can fall in the same cycle with the same target: a flag-producing function whose destination is the flag register itself. The bench provokes this case with directed vectors for every flag-producing code, and randomly sets dst_is_flag on about a quarter of the random vectors. It judges the outcome by requiring res_we low with flag_we high and the correct flag byte. The same stimulus on codes 0 to 3 must leave res_we high.

// File: rtl/vreg_alu.sv
module vreg_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [3:0]   func,
  input  logic [W-1:0] x_val,
  input  logic [W-1:0] y_val,
  input  logic         dst_is_flag,
  output logic [W-1:0] res_data,
  output logic         res_we,
  output logic [W-1:0] flag_data,
  output logic         flag_we
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W:0]   sum, dxy, dyx;
  logic [W-1:0] r_n;
  logic         f_n, def_n, fop_n;

  assign sum = {1'b0, x_val} + {1'b0, y_val};
  assign dxy = {1'b0, x_val} - {1'b0, y_val};
  assign dyx = {1'b0, y_val} - {1'b0, x_val};

  always_comb begin
    r_n   = '0;
    f_n   = 1'b0;
    def_n = 1'b1;
    fop_n = 1'b0;
    unique case (func)
      4'h0: r_n = y_val;
      4'h1: r_n = x_val | y_val;
      4'h2: r_n = x_val & y_val;
      4'h3: r_n = x_val ^ y_val;
      4'h4: begin r_n = sum[W-1:0]; f_n = sum[W];                fop_n = 1'b1; end
      4'h5: begin r_n = dxy[W-1:0]; f_n = !dxy[W] && (x_val != y_val); fop_n = 1'b1; end
      4'h6: begin r_n = x_val >> 1; f_n = x_val[0];              fop_n = 1'b1; end
      4'h7: begin r_n = dyx[W-1:0]; f_n = !dyx[W] && (x_val != y_val); fop_n = 1'b1; end
      4'hE: begin r_n = x_val << 1; f_n = x_val[W-1];            fop_n = 1'b1; end
      default: def_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_we    <= 1'b0;
      flag_data <= '0;
      flag_we   <= 1'b0;
    end else begin
      res_data  <= issue ? r_n : '0;
      res_we    <= issue && def_n && !(fop_n && dst_is_flag);
      flag_data <= (issue && f_n) ? ONE : '0;
      flag_we   <= issue && fop_n;
    end
  end
endmodule

module vreg_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic [3:0] func,
  input logic       dst_is_flag,
  input logic [7:0] res_data,
  input logic       res_we,
  input logic [7:0] flag_data,
  input logic       flag_we
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!res_we && !flag_we));
  // R7
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && func inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hF}) |=> (!res_we && !flag_we && res_data == 8'h00));
  // R8
  flag_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dst_is_flag && func inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hE}) |=> (flag_we && !res_we));
  // R1
  logic_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && func inside {4'h0, 4'h1, 4'h2, 4'h3}) |=> (res_we && !flag_we));
  // R2
  flag_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_data[7:1] == 7'd0));
  // R3
  sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && func == 4'h5 && !dst_is_flag) |=> (res_we && flag_we && (res_data != 8'h00 || flag_data == 8'h00)));
endmodule

bind vreg_alu vreg_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .func(func), .dst_is_flag(dst_is_flag),
  .res_data(res_data), .res_we(res_we), .flag_data(flag_data), .flag_we(flag_we)
);

// File: tb/vreg_alu_tb.sv
module vreg_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [3:0] func = '0;
  logic [7:0] x_val = '0, y_val = '0;
  logic       dst_is_flag = 1'b0;
  logic [7:0] res_data, flag_data;
  logic       res_we, flag_we;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vreg_alu u_dut (.*);

  function automatic string tag(input logic [3:0] f, input logic d);
    if (d && f inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hE}) return "R8";
    case (f)
      4'h0, 4'h1, 4'h2, 4'h3: return "R1";
      4'h4: return "R2";
      4'h5: return "R3";
      4'h7: return "R4";
      4'h6: return "R5";
      4'hE: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [17:0] model(input logic [3:0] f, input logic [7:0] x, input logic [7:0] y, input logic d);
    logic [7:0] r; logic fl, rw, fw; int s;
    r = 0; fl = 0; rw = 1; fw = 1;
    case (f)
      4'h0: begin r = y; fw = 0; end
      4'h1: begin r = x | y; fw = 0; end
      4'h2: begin r = x & y; fw = 0; end
      4'h3: begin r = x ^ y; fw = 0; end
      4'h4: begin s = int'(x) + int'(y); r = 8'(s); fl = s > 255; end
      4'h5: begin r = x - y; fl = x > y; end
      4'h7: begin r = y - x; fl = y > x; end
      4'h6: begin r = {1'b0, x[7:1]}; fl = x[0]; end
      4'hE: begin r = {x[6:0], 1'b0}; fl = x[7]; end
      default: begin rw = 0; fw = 0; end
    endcase
    if (fw && d) rw = 0;
    return {r, 7'd0, fl, rw, fw};
  endfunction

  task automatic chk(input string t, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] f, input logic [7:0] x, input logic [7:0] y, input logic d);
    logic [17:0] e; string t;
    @(negedge clk);
    issue = 1; func = f; x_val = x; y_val = y; dst_is_flag = d;
    @(posedge clk); #1;
    e = model(f, x, y, d); t = tag(f, d);
    chk(t, "res_we", 8'(res_we), 8'(e[1]));
    chk(t, "flag_we", 8'(flag_we), 8'(e[0]));
    if (e[1] || (e[0] && d)) chk(t, "res_data", res_data, e[17:10]);
    if (e[0]) chk(t, "flag_data", flag_data, e[9:2]);
    if (!e[0] && !e[1]) chk(t, "res_data", res_data, 8'h00);
    issue = 0;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1;
    // R10
    chk("R10", "res_we", 8'(res_we), 8'h00);
    chk("R10", "flag_we", 8'(flag_we), 8'h00);
    chk("R10", "res_data", res_data, 8'h00);
    chk("R10", "flag_data", flag_data, 8'h00);
    @(negedge clk); rst_n = 1;
    // directed corners
    run(4'h4, 8'hFF, 8'h01, 0);  // R2 carry at boundary
    run(4'h4, 8'hFE, 8'h01, 0);  // R2 sum exactly 255
    run(4'h5, 8'h10, 8'h10, 0);  // R3 equal -> flag 0
    run(4'h5, 8'h11, 8'h10, 0);  // R3
    run(4'h5, 8'h00, 8'h01, 0);  // R3 wrap
    run(4'h7, 8'h20, 8'h20, 0);  // R4 equal
    run(4'h7, 8'h01, 8'h00, 0);  // R4
    run(4'h6, 8'h81, 8'h00, 0);  // R5
    run(4'hE, 8'h81, 8'h00, 0);  // R6
    run(4'hE, 8'h7F, 8'h00, 0);  // R6
    for (int f = 0; f < 16; f++) begin
      run(4'(f), 8'hA5, 8'h3C, 0);
      run(4'(f), 8'hA5, 8'h3C, 1);  // R8 result/flag collision
    end
    // R9 idle cycle
    @(negedge clk); issue = 0; func = 4'h4; x_val = 8'hFF; y_val = 8'hFF;
    @(posedge clk); #1;
    chk("R9", "res_we idle", 8'(res_we), 8'h00);
    chk("R9", "flag_we idle", 8'(flag_we), 8'h00);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] f;
      f = 4'($urandom);
      run(f, 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule